// File: doc/BRIEF.md
# Eight-Mode Serial Byte Shifter

This block holds one byte and moves it bit by bit through a serial data pin. A 3-bit mode input selects whether bits come in or go out, and where the shift clock comes from. The clock can be a divided clock whose rate is set by an external 8-bit period value N, the system clock itself, or a clock supplied on an input pin. When the block makes the shift clock, it drives that clock out on a clock pin so a peripheral can follow it.

A processor access to the register starts a transfer. A write loads a new byte and starts. A read starts without changing the byte. Either access clears the done flag and resets the modulo-8 bit counter. In the counted internal modes, eight clock pulses are produced, then the clock parks high and the flag rises. In the two external-clock modes, the flag rises on every eighth pulse and shifting carries on. One output mode runs without end: it circulates the byte forever and never raises the flag. Mode 000 turns shifting off, but the register can still be loaded and read.

Control states: IDLE means no transfer is under way. RUN means shifting is enabled. DRAIN lasts one cycle after the eighth internal rising clock edge, and lets the last sampled bit land. Transitions: any mode leads to IDLE when the mode is 000. An access in a mode other than 000 leads to RUN, from any state. RUN moves to DRAIN on the eighth generated rising edge in a counted internal mode. DRAIN always moves to IDLE.

Top module: `serial_byte_shifter`

## Requirements
- R1: After reset: flag is 0, the clock pin output is 1, the register reads 0x00 and the serial data output is 0.
- R2: With mode 000, the clock output never toggles and the flag reads 0 from the cycle after the mode is applied. A write still loads the register, and the register value appears on rd_data.
- R3: A write loads wr_data into the register in the cycle after the access. Any access (read or write) clears the flag one cycle later and restarts the 8-bit count.
- R4: The generated clock idles high and falls first. Each half-period lasts N+2 system cycles in modes 001, 100 and 101, and 1 cycle in modes 010 and 110.
- R5: When shifting in, each bit is sampled in the system cycle after a rising clock edge and enters bit 0. The first received bit therefore ends in bit 7.
- R6: When shifting out, the data pin takes bit 7 one cycle after each falling edge, and bit 7 is rotated into bit 0. After eight shifts the register holds its original byte, and the pin keeps the last bit (original bit 0).
- R7: In modes 001, 010, 101 and 110, exactly 8 falling and 8 rising edges follow an access at edge E0. The flag rises at edge E0+16H+1, where H is the half-period, and the clock then stays high.
- R8: In modes 011 and 111 (shift clock taken from sclk_in), the flag rises after the eighth external pulse and is still 0 after the seventh. A ninth pulse still shifts.
- R9: In mode 100, the byte is sent repeatedly, bit 7 first, and the flag is never set.
- R10: sclk_oe is 1 exactly in modes 001, 010, 100, 101 and 110. sdata_oe equals mode bit 2.
- R11: An access during a transfer restarts it. The timing of R4 and R7 is then counted from the new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Shift mode select |
| rate_n | input | 8 | Divider period value N from the timer |
| acc_rd | input | 1 | Processor read strobe (starts a transfer) |
| acc_wr | input | 1 | Processor write strobe (loads and starts) |
| wr_data | input | 8 | Byte to load on a write |
| rd_data | output | 8 | Current register content |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Clock pin drive enable |
| sdata_in | input | 1 | Serial input data |
| sdata_out | output | 1 | Serial output data |
| sdata_oe | output | 1 | Data pin drive enable |
| flag | output | 1 | Eight-bit transfer done flag |

## Verification
Take an access sampled at edge E0, with half-period H. The first generated fall is due at E0+H, and each later clock edge follows H cycles after the one before it. An output bit is due one cycle after its fall. An input bit is due one cycle after its rise. The flag is due at E0+16H+1. The bench samples one time unit after each clock edge and counts edges from E0, so every comparison lands on the cycle these formulas give. For external clocking, each level on sclk_in is held for three system cycles, which covers the two-register edge detector and the following shift cycle.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

    typedef enum logic [2:0] {
        M_OFF      = 3'b000,
        M_IN_T2    = 3'b001,
        M_IN_SYS   = 3'b010,
        M_IN_EXT   = 3'b011,
        M_OUT_FREE = 3'b100,
        M_OUT_T2   = 3'b101,
        M_OUT_SYS  = 3'b110,
        M_OUT_EXT  = 3'b111
    } smode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } sstate_e;

    function automatic logic mode_ext(input smode_e m);
        return (m == M_IN_EXT) || (m == M_OUT_EXT);
    endfunction

    function automatic logic mode_int(input smode_e m);
        return (m != M_OFF) && !mode_ext(m);
    endfunction

    function automatic logic mode_t2(input smode_e m);
        return (m == M_IN_T2) || (m == M_OUT_FREE) || (m == M_OUT_T2);
    endfunction

    function automatic logic mode_counted_int(input smode_e m);
        return mode_int(m) && (m != M_OUT_FREE);
    endfunction

    function automatic logic mode_out(input smode_e m);
        return (m == M_OUT_FREE) || (m == M_OUT_T2) ||
               (m == M_OUT_SYS)  || (m == M_OUT_EXT);
    endfunction

endpackage

// File: rtl/ssh_clk_gen.sv
module ssh_clk_gen #(
    parameter int RATE_W = 8,
    localparam int HW = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              use_rate,
    input  logic [RATE_W-1:0] rate_n,
    output logic              sclk,
    output logic              rise_tog
);

    logic [HW-1:0] tick_q;
    logic [HW-1:0] lim;

    // half period minus one: N+1 at the divided rate, 0 at system rate
    assign lim = use_rate ? (HW'(rate_n) + HW'(1)) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            sclk   <= 1'b1;
        end else if (restart) begin
            tick_q <= '0;
            sclk   <= 1'b1;
        end else if (run) begin
            if (tick_q == lim) begin
                tick_q <= '0;
                sclk   <= ~sclk;
            end else begin
                tick_q <= tick_q + HW'(1);
            end
        end else begin
            tick_q <= '0;
        end
    end

    assign rise_tog = run && !restart && (tick_q == lim) && !sclk;

    // R4: clock holds its level while not running
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(sclk));

    // R11: an access parks the clock high for a fresh start
    p_restart_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> sclk);

endmodule

// File: rtl/ssh_edge_pick.sv
module ssh_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel_ext,
    input  logic sclk_int,
    input  logic sclk_ext,
    output logic rise_p,
    output logic fall_p
);

    logic int_d;
    logic ext_q1, ext_q2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_d  <= 1'b1;
            ext_q1 <= 1'b1;
            ext_q2 <= 1'b1;
        end else begin
            int_d  <= restart ? 1'b1 : sclk_int;
            ext_q1 <= sclk_ext;
            ext_q2 <= ext_q1;
        end
    end

    always_comb begin
        if (sel_ext) begin
            rise_p = ext_q1 && !ext_q2;
            fall_p = !ext_q1 && ext_q2;
        end else begin
            rise_p = sclk_int && !int_d;
            fall_p = !sclk_int && int_d;
        end
    end

endmodule

// File: rtl/ssh_ctrl.sv
module ssh_ctrl
    import sshift_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             sdata_in,
    input  logic             gen_rise,
    input  logic             rise_p,
    input  logic             fall_p,
    output logic             run_int,
    output logic [WIDTH-1:0] data_q,
    output logic             sdata_out,
    output logic             flag
);

    smode_e     md;
    sstate_e    st_q, st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic       acc, counted, ext, last, active, out_ev, in_ev;

    assign md      = smode_e'(mode);
    assign acc     = acc_rd | acc_wr;
    assign counted = mode_counted_int(md);
    assign ext     = mode_ext(md);
    assign last    = (cnt_q == CNT_W'(WIDTH - 1));
    assign active  = (md != M_OFF) && ((st_q == ST_RUN) || (st_q == ST_DRAIN));
    assign out_ev  = active && mode_out(md) && fall_p;
    assign in_ev   = active && !mode_out(md) && rise_p;
    assign run_int = (st_q == ST_RUN) && mode_int(md);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        if (md == M_OFF) begin
            st_nx = ST_IDLE;
        end else if (acc) begin
            st_nx = ST_RUN;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_nx = ST_IDLE;
                ST_RUN:   if (counted && gen_rise && last) st_nx = ST_DRAIN;
                ST_DRAIN: st_nx = ST_IDLE;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // outputs: counter, flag, data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            flag      <= 1'b0;
            data_q    <= '0;
            sdata_out <= 1'b0;
        end else begin
            if (md == M_OFF || acc) begin
                cnt_q <= '0;
            end else if (st_q == ST_RUN && ((counted && gen_rise) || (ext && rise_p))) begin
                cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            end

            if (md == M_OFF || acc) begin
                flag <= 1'b0;
            end else if (st_q == ST_DRAIN) begin
                flag <= 1'b1;
            end else if (st_q == ST_RUN && ext && rise_p && last) begin
                flag <= 1'b1;
            end

            if (acc_wr) begin
                data_q <= wr_data;
            end else if (out_ev) begin
                data_q    <= {data_q[WIDTH-2:0], data_q[WIDTH-1]};
                sdata_out <= data_q[WIDTH-1];
            end else if (in_ev) begin
                data_q <= {data_q[WIDTH-2:0], sdata_in};
            end
        end
    end

    // R2: disabled mode keeps the flag low
    p_off_noflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (md == M_OFF) |=> !flag);

    // R3: any access clears the flag
    p_access_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !flag);

    // R9: free-running mode never raises the flag
    p_free_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (md == M_OUT_FREE && !flag) |=> !flag);

    // R7: the drain cycle ends with the flag set
    p_drain_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN && !acc && md != M_OFF) |=> (flag && st_q == ST_IDLE));

endmodule

// File: rtl/serial_byte_shifter.sv
module serial_byte_shifter
    import sshift_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [RATE_W-1:0] rate_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    output logic              flag
);

    smode_e md;
    logic   restart, run_int, gen_rise, rise_p, fall_p;

    assign md       = smode_e'(mode);
    assign restart  = acc_rd | acc_wr;
    assign sclk_oe  = mode_int(md);
    assign sdata_oe = mode_out(md);

    ssh_clk_gen #(.RATE_W(RATE_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_int),
        .restart  (restart),
        .use_rate (mode_t2(md)),
        .rate_n   (rate_n),
        .sclk     (sclk_out),
        .rise_tog (gen_rise)
    );

    ssh_edge_pick u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sel_ext  (mode_ext(md)),
        .sclk_int (sclk_out),
        .sclk_ext (sclk_in),
        .rise_p   (rise_p),
        .fall_p   (fall_p)
    );

    ssh_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .wr_data   (wr_data),
        .sdata_in  (sdata_in),
        .gen_rise  (gen_rise),
        .rise_p    (rise_p),
        .fall_p    (fall_p),
        .run_int   (run_int),
        .data_q    (rd_data),
        .sdata_out (sdata_out),
        .flag      (flag)
    );

endmodule

// File: tb/serial_byte_shifter_bench.sv
module serial_byte_shifter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [7:0] rate_n = 8'd0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       sclk_in = 1'b1, sclk_out, sclk_oe;
    logic       sdata_in = 1'b0, sdata_out, sdata_oe, flag;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    serial_byte_shifter u_serial_byte_shifter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_n(rate_n),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .wr_data(wr_data), .rd_data(rd_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe), .flag(flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] d);
        @(negedge clk);
        if (wr) begin acc_wr = 1'b1; wr_data = d; end
        else acc_rd = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
    endtask

    // internal clocked counted run; expected results from R4..R7
    task automatic run_int(input logic [2:0] m, input logic [7:0] n,
                           input logic [7:0] pat, input bit use_wr);
        int h, falls, rises, flag_at, last_edge;
        bit per_ok, bits_ok, prev, cur;
        mode = m; rate_n = n;
        h = (m == 3'd1 || m == 3'd4 || m == 3'd5) ? int'(n) + 2 : 1;
        access(use_wr, pat);
        falls = 0; rises = 0; flag_at = -1; last_edge = 0;
        per_ok = 1; bits_ok = 1; prev = 1'b1;
        for (int j = 1; j <= 16 * h + 6; j++) begin
            @(posedge clk); #1;
            cur = sclk_out;
            if (cur != prev) begin
                if (j - last_edge != h) per_ok = 0;
                last_edge = j;
                if (!cur) falls++;
                else begin
                    if (rises < 8) begin
                        if (m[2] && sdata_out != pat[7 - rises]) bits_ok = 0;
                        if (!m[2]) sdata_in = pat[7 - rises];
                    end
                    rises++;
                end
            end
            if (flag && flag_at < 0) flag_at = j;
            prev = cur;
        end
        chk(falls == 8 && rises == 8, "R7 pulse count", falls + rises, 16);
        chk(per_ok, "R4 half period", 0, 1);
        chk(flag_at == 16 * h + 1, "R7 flag cycle", flag_at, 16 * h + 1);
        chk(sclk_out == 1'b1, "R7 clock parks high", sclk_out, 1);
        if (m[2]) begin
            chk(bits_ok, "R6 out bit order", 0, 1);
            chk(rd_data == pat, "R6 rotate back", rd_data, pat);
            chk(sdata_out == pat[0], "R6 pin holds last", sdata_out, pat[0]);
        end else begin
            chk(rd_data == pat, "R5 shifted-in byte", rd_data, pat);
        end
    endtask

    task automatic ext_pulse(input bit b, output bit seen);
        @(negedge clk); sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        seen = sdata_out;
        sdata_in = b; sclk_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen, ok;
        int toggles, rises;
        bit prev, flag_seen;
        logic [7:0] pat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(flag == 0 && sclk_out == 1 && rd_data == 0 && sdata_out == 0,
            "R1 reset state", {flag, sclk_out, sdata_out}, 3'b010);

        // R10 pin directions for all modes
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m); #1;
            chk(sclk_oe == (m != 0 && m != 3 && m != 7), "R10 sclk_oe", sclk_oe, m);
            chk(sdata_oe == mode[2], "R10 sdata_oe", sdata_oe, m);
        end

        // counted internal runs, sweep modes, rates and patterns
        run_int(3'd1, 8'd0, 8'hA5, 1);
        run_int(3'd1, 8'd3, 8'h3C, 1);
        run_int(3'd2, 8'd0, 8'h5A, 1);
        run_int(3'd5, 8'd0, 8'hC3, 1);
        run_int(3'd5, 8'd2, 8'h81, 1);
        run_int(3'd6, 8'd0, 8'h7E, 1);
        run_int(3'd6, 8'd0, 8'h01, 1);
        // R3 write loads immediately
        mode = 3'd6;
        access(1, 8'hE4);
        #1 chk(rd_data == 8'hE4 && flag == 0, "R3 write load and flag clear", rd_data, 8'hE4);
        // R11 restart mid-transfer with new byte
        repeat (5) @(negedge clk);
        run_int(3'd6, 8'd0, 8'h2D, 1);
        // R11 read access restarts an input transfer
        run_int(3'd2, 8'd0, 8'h99, 0);

        // R8 external clock, shift in
        mode = 3'd3;
        access(1, 8'h00);
        pat = 8'hA7;
        for (int k = 0; k < 8; k++) begin
            ext_pulse(pat[7 - k], seen);
            if (k == 6) chk(flag == 0, "R8 flag low after 7", flag, 0);
        end
        chk(flag == 1, "R8 flag after 8 external pulses", flag, 1);
        chk(rd_data == pat, "R5 external shift-in byte", rd_data, pat);
        ext_pulse(1'b1, seen);
        chk(flag == 1 && rd_data == {pat[6:0], 1'b1}, "R8 shifting continues", rd_data, {pat[6:0], 1'b1});
        access(0, 8'h00);
        #1 chk(flag == 0, "R3 read clears flag", flag, 0);

        // R8/R6 external clock, shift out
        mode = 3'd7;
        pat = 8'h5C;
        access(1, pat);
        ok = 1;
        for (int k = 0; k < 8; k++) begin
            ext_pulse(1'b0, seen);
            if (seen != pat[7 - k]) ok = 0;
        end
        chk(ok, "R6 external out bit order", 0, 1);
        chk(flag == 1 && rd_data == pat, "R8 external out flag and rotate", rd_data, pat);

        // R9 free-running mode
        mode = 3'd4; rate_n = 8'd0;
        pat = 8'h96;
        access(1, pat);
        ok = 1; rises = 0; prev = 1'b1; flag_seen = 0;
        for (int j = 0; j < 120; j++) begin
            @(posedge clk); #1;
            if (sclk_out && !prev) begin
                if (sdata_out != pat[7 - (rises % 8)]) ok = 0;
                rises++;
            end
            if (flag) flag_seen = 1;
            prev = sclk_out;
        end
        chk(ok && rises >= 24, "R9 byte repeats", rises, 24);
        chk(!flag_seen, "R9 flag never set", flag_seen, 0);

        // R2 disabled mode: set flag first in external mode, then disable
        mode = 3'd3;
        access(1, 8'h00);
        for (int k = 0; k < 8; k++) ext_pulse(1'b0, seen);
        chk(flag == 1, "R8 flag before disable", flag, 1);
        mode = 3'd0;
        @(negedge clk);
        chk(flag == 0, "R2 flag cleared when disabled", flag, 0);
        access(1, 8'h3C);
        #1 chk(rd_data == 8'h3C, "R2 write in disabled mode", rd_data, 8'h3C);
        toggles = 0; prev = sclk_out; flag_seen = 0;
        for (int j = 0; j < 40; j++) begin
            @(posedge clk); #1;
            if (sclk_out != prev) toggles++;
            if (flag) flag_seen = 1;
            prev = sclk_out;
        end
        chk(toggles == 0 && !flag_seen && sclk_out == 1, "R2 no clock, no flag", toggles, 0);
        chk(rd_data == 8'h3C, "R2 data unchanged", rd_data, 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule